// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers interrupt sources into a set of priority levels. Each level holds a 64-bit sticky vector of individual sources. A one-bit-per-level summary status word records which levels have any source pending. A command port posts or clears one source at a time, given a level number and a bit index. A further command wipes every level at once. A separate request word carries the software interrupt levels.

Each cycle the block scans the software levels and then the external levels on one shared priority scale, and builds a per-level summary mask. It compares the resolved priority with the current priority mask. When the resolved priority is higher and the program counter is word aligned, it raises an interrupt request. It also loads the summary mask and the winning priority into output registers. Illegal commands and any asynchronous-trap request raise error flags. All resolution results are registered and appear one cycle after the inputs that produced them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A command with op code 0 (post) and a legal level L and index k sets bit k of level L's pending vector. Bit L of `status_o` reads 1 after the next clock edge.
- R2: A command with op code 1 (clear) and a legal level L and index k clears bit k of level L's vector. Bit L of `status_o` drops only if no other bit of that vector remains set.
- R3: A command with op code 2 (clear all) empties every pending vector and drives `status_o` to zero after the next edge.
- R4: A command is illegal if it uses op code 3, or if it is a post or clear whose level is NUM_LVL or more or whose index is 64 or more. An illegal command changes no state, and `cmd_err_o` is 1 in the cycle after it.
- R5: `pend_o` is 1 in the cycle after the status word was nonzero and `pc_low_i` was 2'b00, and 0 otherwise.
- R6: For each set bit i of `sw_req_i` with SW_MIN <= i < SW_MAX, bit i is set in the summary mask. The highest such i gives priority i - SW_MIN + 1. `sw_req_i` bits outside this range have no effect on the summary mask or the priority.
- R7: For each set status bit i with EXT_MIN <= i < EXT_MAX, bit i is set in the summary mask and the level gives priority i. The highest such level overrides any software priority. Status bits outside both ranges contribute to `pend_o` only.
- R8: `irq_o` is 1 in the cycle after a cycle in which three things held: the resolved priority was nonzero, it was strictly greater than `ipl_mask_i`, and `pc_low_i` was 2'b00.
- R9: When a delivery occurs, `isr_o` takes the summary mask and `intid_o` takes the winning priority. Without a delivery both hold their values.
- R10: `unsup_err_o` is 1 in the cycle after a cycle in which `async_req_i` was nonzero.
- R11: A posted source reaches `status_o` after one edge and reaches `irq_o` and `intid_o` after the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid; one command accepted per cycle |
| cmd_op_i | input | 2 | 0 post, 1 clear, 2 clear all, 3 reserved |
| cmd_lvl_i | input | LVL_IN_W | Level number of the command |
| cmd_idx_i | input | IDX_IN_W | Source bit index of the command |
| sw_req_i | input | NUM_LVL | Software interrupt request word, one bit per level |
| async_req_i | input | ASYNC_W | Asynchronous-trap request; must stay zero |
| pc_low_i | input | 2 | Two least significant bits of the current program counter |
| ipl_mask_i | input | clog2(NUM_LVL) | Current priority-level mask |
| status_o | output | NUM_LVL | Summary status word |
| cmd_err_o | output | 1 | Illegal command flag |
| unsup_err_o | output | 1 | Unsupported asynchronous request flag |
| pend_o | output | 1 | Interrupt pending check |
| irq_o | output | 1 | Interrupt delivered |
| isr_o | output | NUM_LVL | Summary mask captured on delivery |
| intid_o | output | clog2(NUM_LVL) | Winning priority captured on delivery |

## Verification
The bench builds the block with 8 levels. The software band is levels 1 to 3 and the external band is levels 4 to 6, so level 0 and level 7 lie outside both scans. This makes the unscanned-level cases cheap to reach: a posted level outside the bands raises the pending check but can never win. The same holds for software bits outside their band. The 5-bit level field and 7-bit index field make out-of-range levels and indices of 64 and above easy to generate. With the 3-bit mask, every comparison between the mask and a priority is hit many times.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    OP_POST    = 2'd0,
    OP_CLR     = 2'd1,
    OP_CLR_ALL = 2'd2,
    OP_RSVD    = 2'd3
  } pirq_op_e;
endpackage

// File: rtl/pirq_src_bank.sv
module pirq_src_bank
  import pirq_pkg::*;
#(
  parameter int NUM_LVL  = 32,
  parameter int SRC_W    = 64,
  parameter int LVL_IN_W = 6,
  parameter int IDX_IN_W = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  pirq_op_e                   cmd_op_i,
  input  logic [LVL_IN_W-1:0]        cmd_lvl_i,
  input  logic [IDX_IN_W-1:0]        cmd_idx_i,
  output logic [NUM_LVL-1:0]         status_o,
  output logic [NUM_LVL*SRC_W-1:0]   pend_vec_o,
  output logic                       cmd_err_o
);
  localparam int LVL_W = $clog2(NUM_LVL);
  localparam int IDX_W = $clog2(SRC_W);

  logic lvl_ok, idx_ok, is_src_op, legal;
  logic do_post, do_clr, do_clr_all;
  logic [SRC_W-1:0] bit_sel;
  logic err_q;

  assign lvl_ok    = 32'(cmd_lvl_i) < NUM_LVL;
  assign idx_ok    = 32'(cmd_idx_i) < SRC_W;
  assign is_src_op = (cmd_op_i == OP_POST) || (cmd_op_i == OP_CLR);
  assign legal     = is_src_op ? (lvl_ok && idx_ok) : (cmd_op_i == OP_CLR_ALL);

  assign do_post    = cmd_valid_i && legal && (cmd_op_i == OP_POST);
  assign do_clr     = cmd_valid_i && legal && (cmd_op_i == OP_CLR);
  assign do_clr_all = cmd_valid_i && legal && (cmd_op_i == OP_CLR_ALL);
  assign bit_sel    = SRC_W'(1) << cmd_idx_i[IDX_W-1:0];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic             hit;
    logic [SRC_W-1:0] vec_q, vec_d;
    logic             stat_q;

    assign hit = (cmd_lvl_i[LVL_W-1:0] == LVL_W'(l));

    always_comb begin
      vec_d = vec_q;
      if (do_clr_all)          vec_d = '0;
      else if (do_post && hit) vec_d = vec_q | bit_sel;
      else if (do_clr && hit)  vec_d = vec_q & ~bit_sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q  <= '0;
        stat_q <= 1'b0;
      end else begin
        vec_q <= vec_d;
        if (do_clr_all)                        stat_q <= 1'b0;
        else if (do_post && hit)               stat_q <= 1'b1;
        else if (do_clr && hit && vec_d == '0) stat_q <= 1'b0;
      end
    end

    assign status_o[l] = stat_q;
    assign pend_vec_o[l*SRC_W +: SRC_W] = vec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cmd_valid_i && !legal;
  end

  assign cmd_err_o = err_q;
endmodule

// File: rtl/pirq_resolve.sv
module pirq_resolve #(
  parameter int NUM_LVL = 32,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 31,
  parameter int IPL_W   = 5
) (
  input  logic [NUM_LVL-1:0] status_i,
  input  logic [NUM_LVL-1:0] sw_req_i,
  input  logic [IPL_W-1:0]   ipl_mask_i,
  input  logic [1:0]         pc_low_i,
  output logic [NUM_LVL-1:0] sum_o,
  output logic [IPL_W-1:0]   ipl_o,
  output logic               deliver_o,
  output logic               pend_o
);
  logic aligned;

  assign aligned = (pc_low_i == 2'b00);

  // ascending scans: last hit wins, external after software
  always_comb begin
    sum_o = '0;
    ipl_o = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req_i[i]) begin
        ipl_o    = IPL_W'(i - SW_MIN + 1);
        sum_o[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (status_i[i]) begin
        ipl_o    = IPL_W'(i);
        sum_o[i] = 1'b1;
      end
    end
  end

  assign pend_o    = (status_i != '0) && aligned;
  assign deliver_o = aligned && (ipl_o != '0) && (ipl_o > ipl_mask_i);
endmodule

// File: rtl/pirq_out_reg.sv
module pirq_out_reg #(
  parameter int NUM_LVL = 32,
  parameter int IPL_W   = 5,
  parameter int ASYNC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               deliver_i,
  input  logic               pend_i,
  input  logic [NUM_LVL-1:0] sum_i,
  input  logic [IPL_W-1:0]   ipl_i,
  input  logic [ASYNC_W-1:0] async_req_i,
  output logic               irq_o,
  output logic               pend_o,
  output logic [NUM_LVL-1:0] isr_o,
  output logic [IPL_W-1:0]   intid_o,
  output logic               unsup_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      pend_o      <= 1'b0;
      isr_o       <= '0;
      intid_o     <= '0;
      unsup_err_o <= 1'b0;
    end else begin
      irq_o       <= deliver_i;
      pend_o      <= pend_i;
      unsup_err_o <= |async_req_i;
      if (deliver_i) begin
        isr_o   <= sum_i;
        intid_o <= ipl_i;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int NUM_LVL  = 32,
  parameter int SRC_W    = 64,
  parameter int SW_MIN   = 1,
  parameter int SW_MAX   = 16,
  parameter int EXT_MIN  = 16,
  parameter int EXT_MAX  = 31,
  parameter int LVL_IN_W = 6,
  parameter int IDX_IN_W = 7,
  parameter int ASYNC_W  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  pirq_op_e                    cmd_op_i,
  input  logic [LVL_IN_W-1:0]         cmd_lvl_i,
  input  logic [IDX_IN_W-1:0]         cmd_idx_i,
  input  logic [NUM_LVL-1:0]          sw_req_i,
  input  logic [ASYNC_W-1:0]          async_req_i,
  input  logic [1:0]                  pc_low_i,
  input  logic [$clog2(NUM_LVL)-1:0]  ipl_mask_i,
  output logic [NUM_LVL-1:0]          status_o,
  output logic                        cmd_err_o,
  output logic                        unsup_err_o,
  output logic                        pend_o,
  output logic                        irq_o,
  output logic [NUM_LVL-1:0]          isr_o,
  output logic [$clog2(NUM_LVL)-1:0]  intid_o
);
  localparam int IPL_W = $clog2(NUM_LVL);

  logic [NUM_LVL*SRC_W-1:0] pend_vec;
  logic [NUM_LVL-1:0]       sum;
  logic [IPL_W-1:0]         ipl;
  logic                     deliver, pend_now;

  pirq_src_bank #(
    .NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LVL_IN_W(LVL_IN_W), .IDX_IN_W(IDX_IN_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_lvl_i(cmd_lvl_i), .cmd_idx_i(cmd_idx_i),
    .status_o(status_o), .pend_vec_o(pend_vec), .cmd_err_o(cmd_err_o)
  );

  pirq_resolve #(
    .NUM_LVL(NUM_LVL), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX), .IPL_W(IPL_W)
  ) u_res (
    .status_i(status_o), .sw_req_i(sw_req_i), .ipl_mask_i(ipl_mask_i),
    .pc_low_i(pc_low_i), .sum_o(sum), .ipl_o(ipl),
    .deliver_o(deliver), .pend_o(pend_now)
  );

  pirq_out_reg #(
    .NUM_LVL(NUM_LVL), .IPL_W(IPL_W), .ASYNC_W(ASYNC_W)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .deliver_i(deliver), .pend_i(pend_now), .sum_i(sum), .ipl_i(ipl),
    .async_req_i(async_req_i),
    .irq_o(irq_o), .pend_o(pend_o), .isr_o(isr_o), .intid_o(intid_o),
    .unsup_err_o(unsup_err_o)
  );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
  parameter int NUM_LVL  = 32,
  parameter int SRC_W    = 64,
  parameter int LVL_IN_W = 6,
  parameter int IDX_IN_W = 7,
  parameter int ASYNC_W  = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cmd_valid_i,
  input logic [1:0]                  cmd_op_i,
  input logic [LVL_IN_W-1:0]         cmd_lvl_i,
  input logic [IDX_IN_W-1:0]         cmd_idx_i,
  input logic [ASYNC_W-1:0]          async_req_i,
  input logic [1:0]                  pc_low_i,
  input logic [$clog2(NUM_LVL)-1:0]  ipl_mask_i,
  input logic [NUM_LVL*SRC_W-1:0]    pend_vec,
  input logic [NUM_LVL-1:0]          status_o,
  input logic                        cmd_err_o,
  input logic                        unsup_err_o,
  input logic                        pend_o,
  input logic                        irq_o,
  input logic [NUM_LVL-1:0]          isr_o,
  input logic [$clog2(NUM_LVL)-1:0]  intid_o
);
  logic bad_cmd;
  assign bad_cmd = cmd_valid_i &&
    ((cmd_op_i == 2'd3) ||
     ((cmd_op_i != 2'd2) && ((32'(cmd_lvl_i) >= NUM_LVL) || (32'(cmd_idx_i) >= SRC_W))));

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    AST_STATUS_TRACKS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[l] == (pend_vec[l*SRC_W +: SRC_W] != '0)); // R2
  end

  AST_CLR_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2) |=> (status_o == '0)); // R3
  AST_BAD_CMD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd |=> cmd_err_o); // R4
  AST_BAD_CMD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd |=> $stable(pend_vec)); // R4
  AST_PEND_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> ($past(status_o) != '0 && $past(pc_low_i) == 2'b00)); // R5
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (intid_o > $past(ipl_mask_i))); // R8
  AST_IRQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(pc_low_i) == 2'b00)); // R8
  AST_HOLD_NO_DELIVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> ($stable(intid_o) && $stable(isr_o))); // R9
  AST_ISR_HAS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (isr_o != '0)); // R9
  AST_ASYNC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_req_i != '0) |=> unsup_err_o); // R10
endmodule

bind prio_irq_ctrl pirq_chk #(
  .NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LVL_IN_W(LVL_IN_W),
  .IDX_IN_W(IDX_IN_W), .ASYNC_W(ASYNC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cmd_lvl_i(cmd_lvl_i), .cmd_idx_i(cmd_idx_i),
  .async_req_i(async_req_i), .pc_low_i(pc_low_i), .ipl_mask_i(ipl_mask_i),
  .pend_vec(pend_vec), .status_o(status_o), .cmd_err_o(cmd_err_o),
  .unsup_err_o(unsup_err_o), .pend_o(pend_o), .irq_o(irq_o),
  .isr_o(isr_o), .intid_o(intid_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NL = 8, SW_LO = 1, SW_HI = 4, EX_LO = 4, EX_HI = 7;
  localparam int LW = 5, IW = 7, AW = 4, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 cmd_valid = 1'b0;
  pirq_pkg::pirq_op_e   cmd_op = pirq_pkg::OP_POST;
  logic [LW-1:0]        cmd_lvl = '0;
  logic [IW-1:0]        cmd_idx = '0;
  logic [NL-1:0]        sw_req = '0;
  logic [AW-1:0]        async_req = '0;
  logic [1:0]           pc_low = '0;
  logic [PW-1:0]        ipl_mask = '0;
  logic [NL-1:0]        status, isr;
  logic                 cmd_err, unsup_err, pend, irq;
  logic [PW-1:0]        intid;

  prio_irq_ctrl #(
    .NUM_LVL(NL), .SRC_W(64), .SW_MIN(SW_LO), .SW_MAX(SW_HI),
    .EXT_MIN(EX_LO), .EXT_MAX(EX_HI), .LVL_IN_W(LW), .IDX_IN_W(IW), .ASYNC_W(AW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_lvl_i(cmd_lvl), .cmd_idx_i(cmd_idx), .sw_req_i(sw_req),
    .async_req_i(async_req), .pc_low_i(pc_low), .ipl_mask_i(ipl_mask),
    .status_o(status), .cmd_err_o(cmd_err), .unsup_err_o(unsup_err),
    .pend_o(pend), .irq_o(irq), .isr_o(isr), .intid_o(intid)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [63:0] mv [NL];
  logic [NL-1:0] ms;
  logic [NL-1:0] e_isr;
  logic [PW-1:0] e_intid;

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, cross posedge, compare at negedge
  task automatic step(input logic v, input logic [1:0] op, input int lvl, input int idx,
                      input logic [NL-1:0] sw, input logic [1:0] pc, input int mask,
                      input logic [AW-1:0] asy);
    logic [NL-1:0] sum = '0;
    int ipl = 0;
    bit ext_win = 1'b0, aligned, e_irq, e_pend, illegal;
    string stag;
    cmd_valid = v; cmd_op = pirq_pkg::pirq_op_e'(op);
    cmd_lvl = LW'(lvl); cmd_idx = IW'(idx);
    sw_req = sw; pc_low = pc; ipl_mask = PW'(mask); async_req = asy;

    for (int i = SW_LO; i < SW_HI; i++) if (sw[i]) begin ipl = i - SW_LO + 1; sum[i] = 1'b1; end
    for (int i = EX_LO; i < EX_HI; i++) if (ms[i]) begin ipl = i; sum[i] = 1'b1; ext_win = 1'b1; end
    aligned = (pc == 2'b00);
    e_pend  = (ms != '0) && aligned;
    e_irq   = aligned && ipl != 0 && ipl > mask;
    if (e_irq) begin e_isr = sum; e_intid = PW'(ipl); end

    illegal = (op == 2'd3) || (op != 2'd2 && (lvl >= NL || idx >= 64));
    stag = "R1";
    if (v && illegal) stag = "R4";
    else if (v && op == 2'd0) begin mv[lvl][idx] = 1'b1; ms[lvl] = 1'b1; stag = "R1"; end
    else if (v && op == 2'd1) begin mv[lvl][idx] = 1'b0; if (mv[lvl] == '0) ms[lvl] = 1'b0; stag = "R2"; end
    else if (v && op == 2'd2) begin for (int l = 0; l < NL; l++) mv[l] = '0; ms = '0; stag = "R3"; end

    @(posedge clk);
    @(negedge clk);
    chk(stag, "status", 64'(status), 64'(ms));
    chk("R4", "cmd_err", 64'(cmd_err), 64'(v && illegal));
    chk("R10", "unsup_err", 64'(unsup_err), 64'(asy != '0));
    chk("R5", "pend", 64'(pend), 64'(e_pend));
    chk("R8", "irq", 64'(irq), 64'(e_irq));
    chk("R9", "isr", 64'(isr), 64'(e_isr));
    chk(ext_win ? "R7" : "R6", "intid", 64'(intid), 64'(e_intid));
  endtask

  task automatic idle(input logic [NL-1:0] sw, input logic [1:0] pc, input int mask);
    step(1'b0, 2'd0, 0, 0, sw, pc, mask, '0);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) mv[l] = '0;
    ms = '0; e_isr = '0; e_intid = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "reset status", 64'(status), 64'd0);
    chk("R8", "reset irq", 64'(irq), 64'd0);
    chk("R9", "reset intid", 64'(intid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // post external level 5, delivery one edge later
    step(1'b1, 2'd0, 5, 3, '0, 2'b00, 0, '0);
    chk("R11", "irq not yet", 64'(irq), 64'd0);
    idle('0, 2'b00, 0);
    chk("R11", "irq after second edge", 64'(irq), 64'd1);
    chk("R7", "intid level5", 64'(intid), 64'd5);
    // clear keeps summary while another bit remains
    step(1'b1, 2'd0, 5, 63, '0, 2'b00, 0, '0);
    step(1'b1, 2'd1, 5, 3, '0, 2'b00, 0, '0);
    chk("R2", "level5 still set", 64'(status[5]), 64'd1);
    step(1'b1, 2'd1, 5, 63, '0, 2'b00, 0, '0);
    chk("R2", "level5 dropped", 64'(status[5]), 64'd0);
    // unscanned levels 0 and 7
    step(1'b1, 2'd0, 0, 0, '0, 2'b00, 0, '0);
    step(1'b1, 2'd0, 7, 10, '0, 2'b00, 0, '0);
    idle('0, 2'b00, 0);
    chk("R7", "unscanned pend only", 64'(irq), 64'd0);
    // illegal commands
    step(1'b1, 2'd0, 9, 0, '0, 2'b00, 0, '0);
    step(1'b1, 2'd0, 2, 64, '0, 2'b00, 0, '0);
    step(1'b1, 2'd1, 0, 127, '0, 2'b00, 0, '0);
    step(1'b1, 2'd3, 4, 1, '0, 2'b00, 0, '0);
    // software band, bit 7 and bit 0 out of band
    idle(8'b1000_1111, 2'b00, 2);
    idle('0, 2'b00, 0);
    chk("R6", "sw priority 3", 64'(intid), 64'd3);
    chk("R6", "sw summary", 64'(isr), 64'b0000_1110);
    idle(8'b0000_1110, 2'b00, 3);
    // external overrides software
    step(1'b1, 2'd0, 4, 1, 8'b0000_1000, 2'b00, 0, '0);
    idle(8'b0000_1000, 2'b00, 0);
    chk("R7", "ext overrides sw", 64'(intid), 64'd4);
    // misaligned pc blocks delivery
    idle(8'b0000_1000, 2'b01, 0);
    idle(8'b0000_1000, 2'b10, 0);
    // async request
    step(1'b0, 2'd0, 0, 0, '0, 2'b00, 0, 4'b0100);
    // clear all
    step(1'b1, 2'd2, 0, 0, '0, 2'b00, 0, '0);
    idle('0, 2'b00, 0);

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 16);
      logic v = ($urandom % 8) != 0;
      logic [1:0] op = (r < 8) ? 2'd0 : (r < 14) ? 2'd1 : (r == 14) ? 2'd2 : 2'd3;
      int lvl = (($urandom % 16) == 0) ? int'($urandom % 32) : int'($urandom % NL);
      int idx = (($urandom % 8) == 0) ? int'($urandom % 128) : int'($urandom % 4);
      logic [NL-1:0] sw = (($urandom % 3) == 0) ? NL'($urandom) : '0;
      logic [1:0] pc = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      int mask = int'($urandom % 8);
      logic [AW-1:0] asy = (($urandom % 32) == 0) ? AW'($urandom) : '0;
      if (op == 2'd2 && ($urandom % 4) != 0) op = 2'd0;
      step(v, op, lvl, idx, sw, pc, mask, asy);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule